// File: doc/BRIEF.md
# Byte FIFO Pair with Occupancy Interrupts

This block holds the data path storage of a serial host controller: one byte-wide queue carries bytes from the host toward the serial shifter, and a second queue carries received bytes back to the host. Each queue is 64 entries deep. The host pushes transmit bytes and pops receive bytes. The shifter pops transmit bytes and pushes receive bytes. Both read ports are show-ahead: the head byte is visible before it is popped.

A level word reports how full each queue is. Three sticky interrupt sources sit beside the queues. One sets when the receive queue is nearly full, so the host can drain it. One sets when the transmit queue is nearly empty, so the host can refill it. One sets when the shifter signals the end of a transfer. The host clears sources by writing ones and masks them through an enable register. A single interrupt line summarises the state. Either queue can be emptied on its own by a one-cycle strobe. The bus decode that turns register accesses into these strobes sits outside the block.

Top module: `byte_fifo_pair_irq`

## Requirements
- R1: Each queue holds up to 64 bytes and returns them in arrival order. The read data port shows the oldest byte, and a pop advances to the next byte one cycle later.
- R2: A push to a full queue is dropped. The count stays at 64 and the stored bytes are unchanged. If a pop and a push reach a full queue in the same cycle, only the pop takes effect.
- R3: A pop from an empty queue leaves the count at 0, and the read data port shows 0 while the queue is empty.
- R4: `level_o` bits 6:0 hold the receive count and bits 22:16 hold the transmit count. All other bits are 0.
- R5: Status bit 4 (receive nearly full) sets on the clock edge after a cycle in which the receive count is 48 or more.
- R6: Status bit 12 (transmit nearly empty) sets on the clock edge after a cycle in which the transmit count is 16 or less.
- R7: Status bit 16 (transfer done) sets on the clock edge that samples `xfer_done_i` high.
- R8: Status bits are sticky. A write with `sts_w1c_i` clears each status bit whose `reg_wdata_i` bit is 1, and leaves bits written with 0 unchanged. If the set condition of a bit holds in the same cycle as its clear, the bit stays set.
- R9: `tx_flush_i` empties only the transmit queue, and `rx_flush_i` empties only the receive queue. Each takes effect in one cycle and overrides a push or pop in that cycle. Neither changes any status bit.
- R10: A write with `ien_we_i` loads bits 4, 12 and 16 of `reg_wdata_i` into the enable register. `ien_o` reads every other bit as 0.
- R11: `irq_o` is high exactly when at least one status bit is both set and enabled.
- R12: While `rst_ni` is low, both counts, all status bits, all enable bits and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Host pushes a transmit byte |
| tx_wdata_i | input | 8 | Transmit byte to push |
| tx_rd_i | input | 1 | Shifter pops a transmit byte |
| tx_rdata_o | output | 8 | Head of the transmit queue (0 when empty) |
| rx_wr_i | input | 1 | Shifter pushes a received byte |
| rx_wdata_i | input | 8 | Received byte to push |
| rx_rd_i | input | 1 | Host pops a received byte |
| rx_rdata_o | output | 8 | Head of the receive queue (0 when empty) |
| tx_flush_i | input | 1 | Empties the transmit queue |
| rx_flush_i | input | 1 | Empties the receive queue |
| xfer_done_i | input | 1 | Transfer-complete pulse from the shifter |
| reg_wdata_i | input | 32 | Write data for the status-clear and enable writes |
| sts_w1c_i | input | 1 | Status write strobe (write-one-to-clear) |
| ien_we_i | input | 1 | Enable register write strobe |
| sts_o | output | 32 | Status word (bits 4, 12, 16) |
| ien_o | output | 32 | Enable word (bits 4, 12, 16) |
| level_o | output | 32 | Receive count in bits 6:0, transmit count in bits 22:16 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks the threshold edges exactly. At counts of 47 and 17 the flags must stay clear, and they must rise one edge after the counts reach 48 and 16. A comparator that is off by one, or that tests the wrong side of a threshold, shows up as a flag that rises too early or never rises. The bench clears a flag while its condition still holds and expects it to stay set; a design in which the clear wins would lose that request. It pushes a 65th byte and expects neither the count nor the stored data to change; a design that lets the write pointer wrap would overwrite the oldest byte. It flushes one queue while a push is pending and expects the other queue's count and every status bit to stay unchanged; a design that shares the flush, or ties status to it, would corrupt one of them.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  typedef logic [31:0] word_t;

  localparam int NSRC = 3;
  localparam int SRC_RX_HI = 0;
  localparam int SRC_TX_LO = 1;
  localparam int SRC_DONE  = 2;

  // Register bit position of each interrupt source; shared by status and enable.
  function automatic int src_bit(int idx);
    case (idx)
      SRC_RX_HI: return 4;
      SRC_TX_LO: return 12;
      default:   return 16;
    endcase
  endfunction

  localparam int LVL_RX_LSB = 0;
  localparam int LVL_TX_LSB = 16;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o);

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !flush_i |=> empty_o && rdata_o == '0);

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/irq_status.sv
module irq_status
  import fifo_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  word_t           wdata_i,
  input  logic            w1c_i,
  input  logic            ien_we_i,
  output word_t           sts_o,
  output word_t           ien_o,
  output logic            irq_o
);
  logic [NSRC-1:0] sts_q, ien_q;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int P = src_bit(g);
    logic clr;
    assign clr = w1c_i & wdata_i[P];

    // Set has priority over clear so a still-present condition is not lost.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[g] <= 1'b0;
      else         sts_q[g] <= set_i[g] | (sts_q[g] & ~clr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ien_q[g] <= 1'b0;
      else if (ien_we_i) ien_q[g] <= wdata_i[P];
    end

    a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr && !set_i[g] |=> !sts_q[g]);

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_q[g] && !clr |=> sts_q[g]);

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> sts_q[g]);
  end

  always_comb begin
    sts_o = '0;
    ien_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      sts_o[src_bit(i)] = sts_q[i];
      ien_o[src_bit(i)] = ien_q[i];
    end
  end

  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/byte_fifo_pair_irq.sv
module byte_fifo_pair_irq
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          tx_rd_i,
  output logic [DW-1:0] tx_rdata_o,
  input  logic          rx_wr_i,
  input  logic [DW-1:0] rx_wdata_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_rdata_o,
  input  logic          tx_flush_i,
  input  logic          rx_flush_i,
  input  logic          xfer_done_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          sts_w1c_i,
  input  logic          ien_we_i,
  output logic [31:0]   sts_o,
  output logic [31:0]   ien_o,
  output logic [31:0]   level_o,
  output logic          irq_o
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int RX_HI = (DEPTH * 3) / 4;
  localparam int TX_LO = DEPTH / 4;

  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [NSRC-1:0] src_set;
  logic            unused_flags;

  assign unused_flags = tx_full ^ tx_empty ^ rx_full ^ rx_empty;

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush_i),
    .push_i  (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (tx_rd_i),
    .rdata_o (tx_rdata_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush_i),
    .push_i  (rx_wr_i),
    .wdata_i (rx_wdata_i),
    .pop_i   (rx_rd_i),
    .rdata_o (rx_rdata_o),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  always_comb begin
    src_set            = '0;
    src_set[SRC_RX_HI] = (rx_cnt >= CW'(RX_HI));
    src_set[SRC_TX_LO] = (tx_cnt <= CW'(TX_LO));
    src_set[SRC_DONE]  = xfer_done_i;
  end

  irq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (src_set),
    .wdata_i  (reg_wdata_i),
    .w1c_i    (sts_w1c_i),
    .ien_we_i (ien_we_i),
    .sts_o    (sts_o),
    .ien_o    (ien_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    level_o = '0;
    level_o[LVL_RX_LSB +: CW] = rx_cnt;
    level_o[LVL_TX_LSB +: CW] = tx_cnt;
  end

  a_r5_rx_hi_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o[LVL_RX_LSB +: CW] >= CW'(RX_HI) |=> sts_o[src_bit(SRC_RX_HI)]);

  a_r6_tx_lo_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o[LVL_TX_LSB +: CW] <= CW'(TX_LO) |=> sts_o[src_bit(SRC_TX_LO)]);

  a_r7_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> sts_o[src_bit(SRC_DONE)]);

  a_r9_rx_flush_keeps_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i && !tx_flush_i && !tx_wr_i && !tx_rd_i |=> $stable(level_o[LVL_TX_LSB +: CW]));

  a_r11_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_o == '0 |-> !irq_o);

  a_r11_no_status_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o == '0 |-> !irq_o);
endmodule

// File: tb/sim_byte_fifo_pair_irq.sv
`timescale 1ns/1ps
module sim_byte_fifo_pair_irq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0;
  logic [7:0]  tx_wdata = '0, rx_wdata = '0;
  logic [7:0]  tx_rdata, rx_rdata;
  logic        tx_flush = 0, rx_flush = 0, xfer_done = 0;
  logic [31:0] reg_wdata = '0;
  logic        sts_w1c = 0, ien_we = 0;
  logic [31:0] sts, ien, level;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done_flag = 0;

  always #2 clk = ~clk;

  byte_fifo_pair_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .tx_rd_i(tx_rd), .tx_rdata_o(tx_rdata),
    .rx_wr_i(rx_wr), .rx_wdata_i(rx_wdata), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .tx_flush_i(tx_flush), .rx_flush_i(rx_flush), .xfer_done_i(xfer_done),
    .reg_wdata_i(reg_wdata), .sts_w1c_i(sts_w1c), .ien_we_i(ien_we),
    .sts_o(sts), .ien_o(ien), .level_o(level), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic tx_push(logic [7:0] b);
    tx_wr = 1; tx_wdata = b; tick(); tx_wr = 0;
  endtask
  task automatic rx_push(logic [7:0] b);
    rx_wr = 1; rx_wdata = b; tick(); rx_wr = 0;
  endtask
  task automatic tx_pop(); tx_rd = 1; tick(); tx_rd = 0; endtask
  task automatic rx_pop(); rx_rd = 1; tick(); rx_rd = 0; endtask

  task automatic w1c(logic [31:0] m);
    reg_wdata = m; sts_w1c = 1; tick(); sts_w1c = 0; reg_wdata = '0;
  endtask
  task automatic ien_wr(logic [31:0] m);
    reg_wdata = m; ien_we = 1; tick(); ien_we = 0; reg_wdata = '0;
  endtask

  task automatic fresh();
    tx_flush = 1; rx_flush = 1; tick(); tx_flush = 0; rx_flush = 0;
    w1c(32'hFFFF_FFFF);
    ien_wr('0);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R12 level in reset", level, 32'h0);
    chk("R12 status in reset", sts, 32'h0);
    chk("R12 enable in reset", ien, 32'h0);
    chk("R12 irq in reset", {31'b0, irq}, 32'h0);
    rst_ni = 1; tick();
  endtask

  task automatic t_order();
    fresh();
    for (int i = 0; i < 5; i++) tx_push(8'hA0 + 8'(i));
    for (int i = 0; i < 3; i++) rx_push(8'h30 + 8'(i));
    chk("R4 level split", level, 32'h0005_0003);
    for (int i = 0; i < 5; i++) begin
      chk("R1 tx order", {24'b0, tx_rdata}, 32'hA0 + i);
      tx_pop();
    end
    for (int i = 0; i < 3; i++) begin
      chk("R1 rx order", {24'b0, rx_rdata}, 32'h30 + i);
      rx_pop();
    end
    chk("R1 both drained", level, 32'h0);
  endtask

  task automatic t_tx_full();
    fresh();
    for (int i = 0; i < 64; i++) tx_push(8'(i));
    chk("R1 tx holds 64", level, 32'h0040_0000);
    tx_push(8'hFF);
    chk("R2 push to full dropped", level, 32'h0040_0000);
    tx_wr = 1; tx_wdata = 8'hEE; tx_rd = 1; tick(); tx_wr = 0; tx_rd = 0;
    chk("R2 push+pop on full", level, 32'h003F_0000);
    for (int i = 1; i < 64; i++) begin
      if (tx_rdata !== 8'(i)) chk("R2 contents kept", {24'b0, tx_rdata}, 32'(i));
      tx_pop();
    end
    chk("R2 drained after full", level, 32'h0);
    chk("R3 tx empty data", {24'b0, tx_rdata}, 32'h0);
  endtask

  task automatic t_rx_empty();
    fresh();
    chk("R3 rx empty data", {24'b0, rx_rdata}, 32'h0);
    rx_pop();
    chk("R3 pop empty count", level, 32'h0);
    rx_push(8'h5A);
    chk("R3 no phantom entry", {24'b0, rx_rdata}, 32'h5A);
    rx_pop();
  endtask

  task automatic t_rx_thresh();
    fresh();
    for (int i = 0; i < 47; i++) rx_push(8'(i));
    tick();
    chk("R5 clear at 47", sts & 32'h10, 32'h0);
    rx_push(8'd47);
    chk("R5 not yet at edge of 48", sts & 32'h10, 32'h0);
    tick();
    chk("R5 set at 48", sts & 32'h10, 32'h10);
    w1c(32'h10);
    chk("R8 set wins over clear", sts & 32'h10, 32'h10);
    rx_pop();
    w1c(32'h10);
    chk("R8 clear at 47", sts & 32'h10, 32'h0);
  endtask

  task automatic t_tx_thresh();
    fresh();
    for (int i = 0; i < 20; i++) tx_push(8'(i));
    w1c(32'h1000);
    chk("R6 cleared at 20", sts & 32'h1000, 32'h0);
    for (int i = 0; i < 3; i++) tx_pop();
    tick();
    chk("R6 clear at 17", sts & 32'h1000, 32'h0);
    tx_pop();
    tick();
    chk("R6 set at 16", sts & 32'h1000, 32'h1000);
  endtask

  task automatic t_done();
    fresh();
    w1c(32'h1000);
    chk("R7 idle", sts & 32'h10000, 32'h0);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R7 done set", sts & 32'h10000, 32'h10000);
    tick();
    chk("R8 done sticky", sts & 32'h10000, 32'h10000);
    w1c(32'hFFFE_FFFF);
    chk("R8 zero bit no effect", sts & 32'h10000, 32'h10000);
    w1c(32'h10000);
    chk("R8 done cleared", sts & 32'h10000, 32'h0);
  endtask

  task automatic t_flush();
    fresh();
    for (int i = 0; i < 5; i++) tx_push(8'(i));
    for (int i = 0; i < 50; i++) rx_push(8'(i));
    tick();
    chk("R9 pre-flush status", sts & 32'h10, 32'h10);
    rx_flush = 1; rx_wr = 1; rx_wdata = 8'h77; tick(); rx_flush = 0; rx_wr = 0;
    chk("R9 rx flushed, tx kept", level, 32'h0005_0000);
    chk("R9 status untouched", sts & 32'h10, 32'h10);
    chk("R9 rx empty after flush", {24'b0, rx_rdata}, 32'h0);
    tx_flush = 1; tick(); tx_flush = 0;
    chk("R9 tx flushed", level, 32'h0);
    chk("R9 status still set", sts & 32'h10, 32'h10);
  endtask

  task automatic t_irq();
    fresh();
    chk("R11 masked", {31'b0, irq}, 32'h0);
    ien_wr(32'hFFFF_FFFF);
    chk("R10 enable bits", ien, 32'h0001_1010);
    chk("R11 tx_lo enabled", {31'b0, irq}, 32'h1);
    ien_wr(32'h10);
    chk("R11 only unset source", {31'b0, irq}, 32'h0);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R11 done but masked", {31'b0, irq}, 32'h0);
    ien_wr(32'h10000);
    chk("R11 done enabled", {31'b0, irq}, 32'h1);
    w1c(32'h10000);
    chk("R11 cleared drops irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_tx_full();
    t_rx_empty();
    t_rx_thresh();
    t_tx_thresh();
    t_done();
    t_flush();
    t_irq();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule